// File: doc/BRIEF.md
# Mixed-Width Dual-Clock FIFO

This block is a first-in first-out buffer whose producer and consumer run on unrelated clocks and see the shared storage through ports of different widths. Widths come from one of two families, 1/2/4 bits or 9/18/36 bits. The two widths must belong to the same family. Either side may be the wider one. When the writer is narrow, several writes build one wide word. When the reader is narrow, one wide word is handed out in several pieces. The physical storage holds `WIDE_DEPTH` words of the wider width. A run-time input limits how much of it is used.

Each side keeps its own address counter. The counters are exchanged between domains in Gray code through two-stage synchronizers, at the granularity of one wide word. The write side derives full and almost-full from its own counter and the synchronized read counter. The read side derives empty and almost-empty the same way. Each side counts in its own word size. Because each side sees the other's counter late, the flags are conservative: they can report too little data or too little space, but never too much. A write that arrives while full is dropped, and so is a read that arrives while empty. Each dropped access sets a sticky indicator in its own domain. Each domain has an asynchronous active-low reset that is released in step with its own clock.

Top module: `mwfifo`

## Requirements
- R1: While both resets are held, `rd_empty`=1, `rd_aempty`=1, `wr_full`=0, `wr_ovf`=0, `rd_unf`=0 and `rd_data`=0. `wr_afull` equals (capacity <= `cfg_afull_thr`).
- R2: When the writer is narrower, the first narrow word written lands in the least-significant bits of the wide word read out. With 9-bit writes and 36-bit reads, writes A,B,C,D read back as {D,C,B,A}. When the reader is narrower, a wide word is returned least-significant part first.
- R3: Data leaves in the order it entered, with nothing lost and nothing duplicated, under concurrent traffic on both clocks.
- R4: `cfg_depth` (1..`WIDE_DEPTH`) gives the usable depth in words of the wider port. Write-side capacity is `cfg_depth` × (wide width / write width) write words. Once both sides are idle for several cycles, `wr_full`=1 exactly when the stored amount equals that capacity.
- R5: Once both sides are idle for several cycles, `rd_empty`=1 exactly when fewer than one read word is held. Only complete wide words written by a narrow writer are visible to the reader.
- R6: Once both sides are idle for several cycles, `wr_afull`=1 exactly when free space, in write words, is <= `cfg_afull_thr`.
- R7: Once both sides are idle for several cycles, `rd_aempty`=1 exactly when the fill, in read words, is <= `cfg_aempty_thr`.
- R8: A write while `wr_full`=1 is dropped: it changes neither the stored data nor the pointers. It sets `wr_ovf`, which stays set until the write-side reset.
- R9: A read while `rd_empty`=1 is dropped: `rd_data` and the pointers are unchanged. It sets `rd_unf`, which stays set until the read-side reset.
- R10: `rd_data` shows the word one read-clock cycle after an accepted read and holds its value on every cycle with no accepted read.
- R11: Under traffic, flags never overstate. If `rd_empty`=0, at least one read word is stored. If `wr_full`=0, space for at least one write word exists. The almost flags obey the same bound. Synchronized pointers change in at most one Gray bit per source cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Write word |
| wr_full | output | 1 | No room for a write word |
| wr_afull | output | 1 | Free space at or below threshold |
| wr_ovf | output | 1 | Sticky: a write was dropped |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_data | output | RD_W | Read word, registered |
| rd_empty | output | 1 | No complete read word available |
| rd_aempty | output | 1 | Fill at or below threshold |
| rd_unf | output | 1 | Sticky: a read was dropped |
| cfg_depth | input | $clog2(WIDE_DEPTH)+1 | Usable depth in wide words, static outside reset |
| cfg_afull_thr | input | PW | Almost-full threshold in write words |
| cfg_aempty_thr | input | PW | Almost-empty threshold in read words |

## Verification
The hardest case to reach from the ports is a flag that overstates while the pointers are in flight between clocks. That happens only when both sides are busy and the FIFO sits near full or near empty at the same time. The stimulus runs two independent clocks of coprime periods with biased random enables, so the writer keeps outrunning the reader against a small programmed depth. On every clock, a queue model checks that no flag claims more than is really stored. Exact flag values are checked only after deliberate idle gaps, at depths that leave a partial wide word pending.

// File: rtl/mwfifo_pkg.sv
package mwfifo_pkg;

  // Widths the storage can present on a port.
  function automatic bit family_member(input int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
  endfunction

  // Both widths must be members and belong to the same family.
  function automatic bit widths_legal(input int a, input int b);
    if (!family_member(a) || !family_member(b)) return 1'b0;
    return ((a % 9) == 0) == ((b % 9) == 0);
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/mwfifo_rst_sync.sv
module mwfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/mwfifo_ptr_sync.sv
module mwfifo_ptr_sync #(
  parameter int W = 8
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic [W-1:0] src_bin,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] gray_d, gray_q;
  logic [W-1:0] meta_q, sync_q;

  always_comb gray_d = src_bin ^ (src_bin >> 1);

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) gray_q <= '0;
    else            gray_q <= gray_d;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_q;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) dst_bin[i] = ^(sync_q >> i);
  end

  AST_GRAY_SINGLE_STEP: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1); // R11
endmodule

// File: rtl/mwfifo_mem.sv
module mwfifo_mem #(
  parameter int NW     = 9,
  parameter int NDEPTH = 512,
  parameter int AW     = 9,
  parameter int WU     = 1,
  parameter int RU     = 4
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WU*NW-1:0] wdata,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [RU*NW-1:0] rdata
);
  logic [NW-1:0]    mem_q [NDEPTH];
  logic [RU*NW-1:0] rdata_d;

  // Write port: narrow slices stored at ascending addresses, low slice first.
  always_ff @(posedge wclk) begin
    if (we) begin
      for (int i = 0; i < WU; i++) mem_q[waddr + AW'(i)] <= wdata[i*NW +: NW];
    end
  end

  always_comb begin
    for (int i = 0; i < RU; i++) rdata_d[i*NW +: NW] = mem_q[raddr + AW'(i)];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata <= '0;
    else if (re)  rdata <= rdata_d;
  end

  AST_RDATA_HOLDS: assert property (@(posedge rclk) disable iff (!rrst_n)
    !re |=> $stable(rdata)); // R10
endmodule

// File: rtl/mwfifo.sv
module mwfifo #(
  parameter int WR_W       = 9,
  parameter int RD_W       = 36,
  parameter int WIDE_DEPTH = 128,
  localparam int NW        = (WR_W < RD_W) ? WR_W : RD_W,
  localparam int WU        = WR_W / NW,
  localparam int RU        = RD_W / NW,
  localparam int KW        = $clog2(WU),
  localparam int KR        = $clog2(RU),
  localparam int K         = (KW > KR) ? KW : KR,
  localparam int NDEPTH    = WIDE_DEPTH << K,
  localparam int AW        = $clog2(NDEPTH),
  localparam int PW        = AW + 1,
  localparam int SW        = PW - K
) (
  input  logic            wr_clk,
  input  logic            wr_rst_n,
  input  logic            wr_en,
  input  logic [WR_W-1:0] wr_data,
  output logic            wr_full,
  output logic            wr_afull,
  output logic            wr_ovf,
  input  logic            rd_clk,
  input  logic            rd_rst_n,
  input  logic            rd_en,
  output logic [RD_W-1:0] rd_data,
  output logic            rd_empty,
  output logic            rd_aempty,
  output logic            rd_unf,
  input  logic [SW-1:0]   cfg_depth,
  input  logic [PW-1:0]   cfg_afull_thr,
  input  logic [PW-1:0]   cfg_aempty_thr
);
  if (!mwfifo_pkg::widths_legal(WR_W, RD_W) || !mwfifo_pkg::is_pow2(WIDE_DEPTH)) begin : g_bad_params
    $error("mwfifo: port widths or depth outside the supported shapes");
  end

  logic wr_rst_i, rd_rst_i;

  mwfifo_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(wr_rst_n), .rst_n_sync(wr_rst_i));
  mwfifo_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rd_rst_n), .rst_n_sync(rd_rst_i));

  // Pointers count narrow slices; the wider side steps by its slice count.
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [SW-1:0] rptr_at_w, wptr_at_r;
  logic [PW-1:0] w_fill, w_cap, w_free, r_fill, r_cap;
  logic          wr_acc, rd_acc;
  logic          ovf_q, ovf_d, unf_q, unf_d;

  mwfifo_ptr_sync #(.W(SW)) u_w2r (
    .src_clk(wr_clk), .src_rst_n(wr_rst_i), .src_bin(wptr_q[PW-1:K]),
    .dst_clk(rd_clk), .dst_rst_n(rd_rst_i), .dst_bin(wptr_at_r)
  );

  mwfifo_ptr_sync #(.W(SW)) u_r2w (
    .src_clk(rd_clk), .src_rst_n(rd_rst_i), .src_bin(rptr_q[PW-1:K]),
    .dst_clk(wr_clk), .dst_rst_n(wr_rst_i), .dst_bin(rptr_at_w)
  );

  // ---------------- write domain ----------------
  always_comb begin
    w_fill   = (wptr_q - (PW'(rptr_at_w) << K)) >> KW;
    w_cap    = PW'(cfg_depth) << (K - KW);
    wr_full  = (w_fill >= w_cap);
    w_free   = w_cap - w_fill;
    wr_afull = (w_free <= cfg_afull_thr);
    wr_acc   = wr_en & ~wr_full;
    wptr_d   = wr_acc ? (wptr_q + PW'(WU)) : wptr_q;
    ovf_d    = ovf_q | (wr_en & wr_full);
  end

  always_ff @(posedge wr_clk or negedge wr_rst_i) begin
    if (!wr_rst_i) begin
      wptr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      ovf_q  <= ovf_d;
    end
  end

  assign wr_ovf = ovf_q;

  // ---------------- read domain ----------------
  always_comb begin
    r_fill    = ((PW'(wptr_at_r) << K) - rptr_q) >> KR;
    r_cap     = PW'(cfg_depth) << (K - KR);
    rd_empty  = (r_fill == '0);
    rd_aempty = (r_fill <= cfg_aempty_thr);
    rd_acc    = rd_en & ~rd_empty;
    rptr_d    = rd_acc ? (rptr_q + PW'(RU)) : rptr_q;
    unf_d     = unf_q | (rd_en & rd_empty);
  end

  always_ff @(posedge rd_clk or negedge rd_rst_i) begin
    if (!rd_rst_i) begin
      rptr_q <= '0;
      unf_q  <= 1'b0;
    end else begin
      rptr_q <= rptr_d;
      unf_q  <= unf_d;
    end
  end

  assign rd_unf = unf_q;

  mwfifo_mem #(.NW(NW), .NDEPTH(NDEPTH), .AW(AW), .WU(WU), .RU(RU)) u_mem (
    .wclk(wr_clk), .we(wr_acc), .waddr(wptr_q[AW-1:0]), .wdata(wr_data),
    .rclk(rd_clk), .rrst_n(rd_rst_i), .re(rd_acc), .raddr(rptr_q[AW-1:0]), .rdata(rd_data)
  );

  // ---------------- assertions ----------------
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wr_clk) disable iff (!wr_rst_i)
    (wr_en && wr_full) |=> (wptr_q == $past(wptr_q))); // R8
  AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (!wr_rst_i)
    wr_ovf |=> wr_ovf); // R8
  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rd_clk) disable iff (!rd_rst_i)
    (rd_en && rd_empty) |=> (rptr_q == $past(rptr_q))); // R9
  AST_UNF_STICKY: assert property (@(posedge rd_clk) disable iff (!rd_rst_i)
    rd_unf |=> rd_unf); // R9
  AST_WR_FILL_WITHIN_DEPTH: assert property (@(posedge wr_clk) disable iff (!wr_rst_i)
    w_fill <= w_cap); // R4
  AST_RD_FILL_WITHIN_DEPTH: assert property (@(posedge rd_clk) disable iff (!rd_rst_i)
    r_fill <= r_cap); // R5
endmodule

// File: tb/tb_mwfifo.sv
module tb_mwfifo;
  localparam int WW  = 9;
  localparam int RW  = 36;
  localparam int RAT = RW / WW;
  localparam int WD  = 128;
  localparam int PW  = $clog2(WD * RAT) + 1;
  localparam int SW  = $clog2(WD) + 1;

  logic          wr_clk, wr_rst_n, wr_en;
  logic [WW-1:0] wr_data;
  logic          wr_full, wr_afull, wr_ovf;
  logic          rd_clk, rd_rst_n, rd_en;
  logic [RW-1:0] rd_data;
  logic          rd_empty, rd_aempty, rd_unf;
  logic [SW-1:0] cfg_depth;
  logic [PW-1:0] cfg_afull_thr, cfg_aempty_thr;

  mwfifo #(.WR_W(WW), .RD_W(RW), .WIDE_DEPTH(WD)) dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_afull(wr_afull), .wr_ovf(wr_ovf),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_aempty(rd_aempty), .rd_unf(rd_unf),
    .cfg_depth(cfg_depth), .cfg_afull_thr(cfg_afull_thr), .cfg_aempty_thr(cfg_aempty_thr)
  );

  // One time unit is 1 ns: write clock 8 units (125 MHz), read clock 11 units.
  initial begin
    wr_clk = 1'b0;
    forever #4 wr_clk = ~wr_clk;
  end
  initial begin
    rd_clk = 1'b0;
    forever begin
      #6 rd_clk = 1'b1;
      #5 rd_clk = 1'b0;
    end
  end

  int compared   = 0;
  int mismatched = 0;
  logic [WW-1:0] q[$];
  logic [RW-1:0] rd_exp;
  bit   inv_on;
  int   depth_w, afthr, aethr;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_step(input bit en, input logic [WW-1:0] d);
    @(negedge wr_clk);
    if (inv_on) begin
      chk("R11", 64'(!wr_full && (q.size() >= depth_w * RAT)), 0, "full flag overstates space");
      chk("R11", 64'(!wr_afull && ((depth_w * RAT - q.size()) <= afthr)), 0, "almost-full overstates space");
    end
    wr_en   = en;
    wr_data = d;
    if (en && !wr_full) q.push_back(d);
  endtask

  task automatic rd_step(input bit en, input string tag);
    @(negedge rd_clk);
    chk(tag, 64'(rd_data), 64'(rd_exp), "read data");
    if (inv_on) begin
      chk("R11", 64'(!rd_empty && (q.size() < RAT)), 0, "empty flag overstates data");
      chk("R11", 64'(!rd_aempty && ((q.size() / RAT) <= aethr)), 0, "almost-empty overstates data");
    end
    rd_en = en;
    if (en && !rd_empty && (q.size() >= RAT)) begin
      for (int i = 0; i < RAT; i++) rd_exp[i*WW +: WW] = q.pop_front();
    end
  endtask

  task automatic quiet();
    fork
      repeat (10) wr_step(1'b0, '0);
      repeat (10) rd_step(1'b0, "R10");
    join
  endtask

  task automatic chk_settled();
    int units, cap;
    units = q.size();
    cap   = depth_w * RAT;
    chk("R4", 64'(wr_full),   64'(units >= cap), "settled full");
    chk("R6", 64'(wr_afull),  64'((cap - units) <= afthr), "settled almost-full");
    chk("R5", 64'(rd_empty),  64'((units / RAT) == 0), "settled empty");
    chk("R7", 64'(rd_aempty), 64'((units / RAT) <= aethr), "settled almost-empty");
  endtask

  task automatic do_reset(input int depth, input int af, input int ae);
    inv_on = 0;
    wr_rst_n = 1'b0;
    rd_rst_n = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    wr_data = '0;
    depth_w = depth;
    afthr = af;
    aethr = ae;
    cfg_depth = SW'(depth);
    cfg_afull_thr = PW'(af);
    cfg_aempty_thr = PW'(ae);
    q.delete();
    rd_exp = '0;
    repeat (4) @(negedge rd_clk);
    chk("R1", 64'(rd_empty),  1, "reset empty");
    chk("R1", 64'(rd_aempty), 1, "reset almost-empty");
    chk("R1", 64'(wr_full),   0, "reset full");
    chk("R1", 64'(wr_afull),  64'((depth * RAT) <= af), "reset almost-full");
    chk("R1", 64'(wr_ovf),    0, "reset overflow");
    chk("R1", 64'(rd_unf),    0, "reset underflow");
    chk("R1", 64'(rd_data),   0, "reset read data");
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
    inv_on = 1;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    do_reset(5, 3, 1);
    quiet();
    chk_settled();

    // Read while empty: dropped, data held, sticky underflow.
    repeat (3) rd_step(1'b1, "R9");
    rd_step(1'b0, "R9");
    chk("R9", 64'(rd_unf), 1, "underflow sticky after read on empty");
    chk("R9", 64'(rd_data), 0, "read data unchanged by dropped read");
    chk("R8", 64'(wr_ovf), 0, "no overflow yet");

    // One wide word built from four narrow writes.
    wr_step(1'b1, 9'h1A5);
    wr_step(1'b1, 9'h0F3);
    wr_step(1'b1, 9'h12C);
    wr_step(1'b1, 9'h07E);
    wr_step(1'b0, '0);
    quiet();
    chk_settled();
    rd_step(1'b1, "R2");
    rd_step(1'b0, "R10");
    chk("R2", 64'(rd_data), 64'({9'h07E, 9'h12C, 9'h0F3, 9'h1A5}), "least-significant slice written first");
    rd_step(1'b0, "R10");
    rd_step(1'b0, "R10");

    // Three narrow writes: not a complete wide word, reader must still see empty.
    for (int i = 0; i < 3; i++) wr_step(1'b1, 9'(i + 17));
    wr_step(1'b0, '0);
    quiet();
    chk_settled();
    chk("R5", 64'(rd_empty), 1, "partial wide word invisible to reader");

    // Fill past the programmed depth.
    for (int i = 0; i < 24; i++) wr_step(1'b1, 9'(i * 37 + 5));
    wr_step(1'b0, '0);
    quiet();
    chk_settled();
    chk("R4", 64'(q.size()), 64'(5 * RAT), "accepted amount equals programmed depth");
    chk("R8", 64'(wr_ovf), 1, "overflow sticky after write on full");

    // Concurrent traffic, writer biased faster than reader.
    fork
      for (int i = 0; i < 2000; i++) wr_step(($urandom % 4) != 0, 9'($urandom));
      for (int i = 0; i < 1500; i++) rd_step(($urandom % 3) != 0, "R3");
    join
    fork
      repeat (10) wr_step(1'b0, '0);
      repeat (40) rd_step(1'b1, "R3");
    join
    rd_step(1'b0, "R3");
    quiet();
    chk_settled();
    chk("R8", 64'(wr_ovf), 1, "overflow still set");

    // Full physical depth after a fresh reset.
    do_reset(WD, 10, 4);
    quiet();
    chk_settled();
    fork
      for (int i = 0; i < WD * RAT + 8; i++) wr_step(1'b1, 9'(i * 11 + 3));
      repeat (WD * RAT + 8) rd_step(1'b0, "R10");
    join
    wr_step(1'b0, '0);
    quiet();
    chk_settled();
    chk("R4", 64'(wr_full), 1, "full at maximum depth");
    fork
      repeat (10) wr_step(1'b0, '0);
      repeat (WD + 12) rd_step(1'b1, "R3");
    join
    rd_step(1'b0, "R3");
    quiet();
    chk_settled();
    chk("R5", 64'(rd_empty), 1, "empty after draining maximum depth");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule